// File: doc/BRIEF.md
# Quadrature Encoder Velocity Period Capture

This block measures shaft speed by timing how long a fixed number of encoder steps takes. Two quadrature phase signals are synchronized and decoded at full resolution, so each single-phase transition, in either direction, counts as one velocity step. A postscaler passes only every Nth step, with N chosen from 1, 4, 16 or 64. Each step it passes becomes a capture strobe. A 16-bit period timer counts system clocks while velocity mode is on. On every capture strobe the timer value is copied into a velocity register.

Firmware chooses whether a capture also restarts the timer. With restart on, the velocity register holds the length of the last N-step interval in clocks. With restart off, the timer runs on, and software takes the difference between two captures. Every capture sets a sticky flag. The flag reaches the interrupt line only when the interrupt is enabled. The postscaler ratio survives a disable/enable cycle of velocity mode.

Top module: `qvel_capture`

## Requirements
- R1: After a two-flop synchronizer, every transition of exactly one phase is one velocity step, in the forward or reverse direction. The bench steps the phases through the Gray sequence (A,B) = 00, 01, 11, 10.
- R2: A sample in which both phases changed together produces no velocity step, so it causes no capture.
- R3: The ratio code sets the steps per capture: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. The step counter restarts when velocity mode is disabled or a ratio write is accepted. The first capture after either of these comes on the Nth step.
- R4: A capture copies the period timer value into `vel_o`.
- R5: With `clr_on_cap_i` = 1, the timer reads 0 one cycle after the capture edge. With steps every P clocks at ratio N, every capture after the first therefore reads N*P-2.
- R6: With `clr_on_cap_i` = 0, the timer keeps counting through captures. Two consecutive captures then differ by exactly N*P.
- R7: The timer adds one per clock while `vel_en_i` = 1. It holds its value while velocity mode is off, so enabling the mode does not change it. It stops at FFFFh and does not wrap.
- R8: A ratio write (`ratio_we_i`) is accepted only while velocity mode is on. The ratio in use is kept across a disable, and it is the ratio in force after re-enable (`ratio_o`).
- R9: A capture sets `cap_flag_o` on the third rising edge after a phase change is applied. A one-cycle `irq_clr_i` clears the flag. If a clear and a capture fall in the same cycle, the flag stays set.
- R10: `irq_o` is `cap_flag_o` AND `irq_en_i`.
- R11: After reset, `vel_o`, `timer_o`, `ratio_o`, `cap_flag_o` and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a_i | input | 1 | Encoder phase A (asynchronous) |
| phase_b_i | input | 1 | Encoder phase B (asynchronous) |
| vel_en_i | input | 1 | Velocity mode enable |
| ratio_we_i | input | 1 | Ratio write strobe |
| ratio_i | input | 2 | Ratio code to write |
| clr_on_cap_i | input | 1 | Restart the timer after each capture |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | One-cycle clear of the capture flag |
| vel_o | output | 16 | Velocity register (last captured timer value) |
| timer_o | output | 16 | Period timer |
| ratio_o | output | 2 | Ratio code in force |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Gated interrupt |

## Verification
The bench sweeps all four ratio codes at two step spacings, in both directions and with restart on and off. It checks that the first capture lands on exactly the Nth step. A postscaler that is off by one would capture one step early or late, and a late timer clear would bias every N*P-2 reading. A both-phases-change sample must leave the flag clear, or a decoder that counts it would capture spuriously. The bench also targets a clear pulse that coincides with a capture, which a naive flag would lose. It checks that a ratio write made while disabled is ignored and that the earlier ratio is back after re-enable. Finally, it runs the timer past 65535 clocks, where a wrapping counter would show a small value.

// File: rtl/qvel_pkg.sv
package qvel_pkg;
  typedef logic [1:0] ratio_t;

  // Steps per capture for a ratio code: 4^code.
  function automatic int unsigned ratio_steps(ratio_t code);
    return 32'd1 << (2 * code);
  endfunction

  // One legal quadrature step: exactly one phase moved.
  function automatic logic x4_step(logic a_old, logic b_old, logic a_new, logic b_new);
    return (a_old ^ a_new) ^ (b_old ^ b_new);
  endfunction
endpackage

// File: rtl/qvel_x4_decode.sv
module qvel_x4_decode #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_a_i,
  input  logic phase_b_i,
  output logic step_o
);
  import qvel_pkg::*;

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] a_sh, b_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh <= '0;
      b_sh <= '0;
    end else begin
      a_sh <= {a_sh[DEPTH-2:0], phase_a_i};
      b_sh <= {b_sh[DEPTH-2:0], phase_b_i};
    end
  end

  assign step_o = x4_step(a_sh[DEPTH-1], b_sh[DEPTH-1], a_sh[DEPTH-2], b_sh[DEPTH-2]);
endmodule

// File: rtl/qvel_postscale.sv
module qvel_postscale #(
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          step_i,
  input  logic          we_i,
  input  logic [RW-1:0] ratio_i,
  output logic [RW-1:0] ratio_o,
  output logic          stb_o
);
  import qvel_pkg::*;

  localparam int CW = 2 * ((1 << RW) - 1);

  logic [RW-1:0] ratio_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          wr_ok;

  assign limit = CW'(ratio_steps(ratio_t'(ratio_q)) - 1);
  assign wr_ok = en_i & we_i;
  assign stb_o = en_i & step_i & (cnt_q == limit);
  assign ratio_o = ratio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ratio_q <= '0;
    else if (wr_ok) ratio_q <= ratio_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en_i || wr_ok)   cnt_q <= '0;
    else if (stb_o)            cnt_q <= '0;
    else if (step_i)           cnt_q <= cnt_q + 1'b1;
  end

  AST_NO_STROBE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !stb_o); // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R3
  AST_RATIO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(ratio_q)); // R8
endmodule

// File: rtl/qvel_period_timer.sv
module qvel_period_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          stb_i,
  input  logic          clr_on_cap_i,
  output logic [TW-1:0] timer_o,
  output logic [TW-1:0] vel_o
);
  localparam logic [TW-1:0] TMAX = '1;

  logic [TW-1:0] timer_q, vel_q;
  logic          clr_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q    <= '0;
      vel_q      <= '0;
      clr_pend_q <= 1'b0;
    end else begin
      clr_pend_q <= stb_i & clr_on_cap_i;
      if (stb_i) vel_q <= timer_q;
      if (clr_pend_q)                  timer_q <= '0;
      else if (en_i && timer_q != TMAX) timer_q <= timer_q + 1'b1;
    end
  end

  assign timer_o = timer_q;
  assign vel_o   = vel_q;

  AST_VEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> vel_q == $past(timer_q)); // R4
  AST_CLEAR_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && clr_on_cap_i |=> ##1 timer_q == '0); // R5
  AST_RUN_THROUGH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && !clr_on_cap_i && en_i && !clr_pend_q && timer_q != TMAX
    |=> timer_q == TW'($past(timer_q) + 1'b1)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !clr_pend_q && timer_q != TMAX |=> timer_q == TW'($past(timer_q) + 1'b1)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    timer_q == TMAX && !clr_pend_q |=> timer_q == TMAX); // R7
endmodule

// File: rtl/qvel_capture.sv
module qvel_capture #(
  parameter int TW          = 16,
  parameter int RW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_a_i,
  input  logic          phase_b_i,
  input  logic          vel_en_i,
  input  logic          ratio_we_i,
  input  logic [RW-1:0] ratio_i,
  input  logic          clr_on_cap_i,
  input  logic          irq_en_i,
  input  logic          irq_clr_i,
  output logic [TW-1:0] vel_o,
  output logic [TW-1:0] timer_o,
  output logic [RW-1:0] ratio_o,
  output logic          cap_flag_o,
  output logic          irq_o
);
  logic step_evt;
  logic cap_stb;
  logic cap_flag_q;

  qvel_x4_decode #(.SYNC_STAGES(SYNC_STAGES)) decode_i (
    .clk(clk), .rst_n(rst_n),
    .phase_a_i(phase_a_i), .phase_b_i(phase_b_i),
    .step_o(step_evt)
  );

  qvel_postscale #(.RW(RW)) post_i (
    .clk(clk), .rst_n(rst_n), .en_i(vel_en_i), .step_i(step_evt),
    .we_i(ratio_we_i), .ratio_i(ratio_i), .ratio_o(ratio_o), .stb_o(cap_stb)
  );

  qvel_period_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .en_i(vel_en_i), .stb_i(cap_stb),
    .clr_on_cap_i(clr_on_cap_i), .timer_o(timer_o), .vel_o(vel_o)
  );

  // Capture wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cap_flag_q <= 1'b0;
    else if (cap_stb)   cap_flag_q <= 1'b1;
    else if (irq_clr_i) cap_flag_q <= 1'b0;
  end

  assign cap_flag_o = cap_flag_q;
  assign irq_o      = cap_flag_q & irq_en_i;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> cap_flag_q); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_i && !cap_stb |=> !cap_flag_q); // R9
  AST_CAP_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> step_evt && vel_en_i); // R2
endmodule

// File: tb/qvel_capture_tb_top.sv
`timescale 1ns/1ps
module qvel_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, en = 1'b0, we = 1'b0, clr_cap = 1'b0, ien = 1'b0, iclr = 1'b0;
  logic [1:0] rin = 2'b00;
  logic [15:0] vel, tmr;
  logic [1:0] rout;
  logic flag, irq;

  int checks = 0;
  int errors = 0;
  int pos = 0;

  always #4 clk = ~clk;

  qvel_capture dut_i (
    .clk(clk), .rst_n(rst_n), .phase_a_i(pa), .phase_b_i(pb),
    .vel_en_i(en), .ratio_we_i(we), .ratio_i(rin), .clr_on_cap_i(clr_cap),
    .irq_en_i(ien), .irq_clr_i(iclr), .vel_o(vel), .timer_o(tmr),
    .ratio_o(rout), .cap_flag_o(flag), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_phase();
    case (pos & 3)
      0: begin pa = 1'b0; pb = 1'b0; end
      1: begin pa = 1'b0; pb = 1'b1; end
      2: begin pa = 1'b1; pb = 1'b1; end
      default: begin pa = 1'b1; pb = 1'b0; end
    endcase
  endtask

  task automatic step(input bit fwd, input int gap);
    pos = fwd ? pos + 1 : pos + 3;
    set_phase();
    tick(gap);
  endtask

  task automatic write_ratio(input logic [1:0] code);
    rin = code; we = 1'b1; tick(1); we = 1'b0;
  endtask

  task automatic clear_flag();
    iclr = 1'b1; tick(1); iclr = 1'b0;
  endtask

  // Sweep one configuration; expected values from the R3/R5/R6 arithmetic.
  task automatic run_cfg(input logic [1:0] code, input int gap, input bit clr, input bit fwd);
    int n = 1 << (2 * code);
    int v2 = 0;
    clr_cap = clr;
    write_ratio(code);
    tick(3);
    clear_flag();
    for (int i = 1; i <= 3 * n; i++) begin
      step(fwd, gap);
      if (i == n - 1) check("R3 no capture before Nth step", flag, 0);
      if (i == n)     check("R1/R3 capture on Nth step", flag, 1);
      if (i == 2 * n) v2 = vel;
    end
    if (clr) check("R5 vel = N*P-2", vel, n * gap - 2);
    else     check("R6 capture difference = N*P", vel - v2, n * gap);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int t0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    check("R11 vel", vel, 0);
    check("R11 timer", tmr, 0);
    check("R11 ratio", rout, 0);
    check("R11 flag", flag, 0);
    check("R11 irq", irq, 0);

    // R7: timer holds while disabled, enabling does not disturb it
    t0 = tmr;
    tick(5);
    check("R7 hold while disabled", tmr, t0);
    en = 1'b1;
    tick(1);
    check("R7 enable keeps value then counts", tmr, t0 + 1);
    tick(9);
    check("R7 one per clock", tmr, t0 + 10);

    // Main sweeps: restart on (R5) and off (R6), both directions
    for (int c = 0; c < 4; c++) run_cfg(2'(c), 3, 1'b1, 1'b1);
    for (int c = 0; c < 4; c++) run_cfg(2'(c), 7, 1'b1, 1'b0);
    for (int c = 0; c < 4; c++) run_cfg(2'(c), 5, 1'b0, c[0]);

    // R2: both phases flip at once -> no step
    write_ratio(2'b00);
    tick(3);
    clear_flag();
    t0 = vel;
    pos = pos + 2; set_phase();
    tick(6);
    check("R2 simultaneous change gives no capture", flag, 0);
    check("R2 velocity unchanged", vel, t0);
    step(1'b1, 4);
    check("R1 legal step after illegal one captures", flag, 1);

    // R9: clear coinciding with capture keeps flag; clear alone drops it
    clear_flag();
    tick(2);
    pos = pos + 1; set_phase();   // applied before edge k
    tick(2);                      // past edges k and k+1
    iclr = 1'b1;
    tick(1);                      // capture edge k+2
    iclr = 1'b0;
    check("R9 capture beats same-cycle clear", flag, 1);
    ien = 1'b0;
    check("R10 irq masked", irq, 0);
    ien = 1'b1;
    #1;
    check("R10 irq passes", irq, 1);
    clear_flag();
    check("R9 clear alone", flag, 0);
    check("R10 irq follows flag", irq, 0);

    // R8: ratio kept over disable, write while disabled ignored
    write_ratio(2'b01);
    check("R8 write accepted while enabled", rout, 1);
    en = 1'b0;
    tick(1);
    write_ratio(2'b11);
    check("R8 write ignored while disabled", rout, 1);
    en = 1'b1;
    tick(1);
    check("R8 ratio restored on re-enable", rout, 1);

    // R3: disable restarts the step count
    tick(3);
    clear_flag();
    step(1'b1, 4); step(1'b1, 4);
    en = 1'b0; tick(1); en = 1'b1; tick(1);
    step(1'b1, 4); step(1'b1, 4); step(1'b1, 4);
    check("R3 disable restarts count (3 steps)", flag, 0);
    step(1'b1, 4);
    check("R3 capture on 4th step after re-enable", flag, 1);

    // R7: saturation at FFFFh
    clr_cap = 1'b0;
    tick(66000);
    check("R7 saturates", tmr, 16'hFFFF);
    tick(3);
    check("R7 no wrap", tmr, 16'hFFFF);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule